// File: doc/BRIEF.md
# Signed-Amount Barrel Shifter with Guard Word

This block shifts a 16-bit operand by a signed amount in one clock and keeps the full 32-bit result. The result is split into two 16-bit registers. The result word holds the shifted operand. The guard word holds the bits that left the 16-bit field. A positive amount shifts left and a negative amount shifts right. The operand is taken from one of two 24-bit accumulators or from a 16-bit source word. The amount is taken from one of the accumulators or from a 6-bit amount word.

Three operations are offered: logical shift, arithmetic shift, and a double-precision pass. The double-precision pass leaves the result word alone. It ORs the logically shifted half of a second operand into the guard word. Two passes therefore build a 32-bit shift: lower word then upper word for a left shift, and upper word then lower word for a right shift. Every write also updates the carry, negative, zero and shifter-overflow flags.

The block is a datapath with no sequencing of its own. It has no states or transitions. Each cycle with `go` high is one independent operation.

Top module: `dsp_shift_unit`

## Requirements
- R1: After reset, the result word, the guard word and all four flags read zero.
- R2: `src_sel` code 0 selects `acc0`, code 1 selects `acc1`, and codes 2 and 3 select `src_word`. Only bits 15:0 of an accumulator are used.
- R3: `amt_sel` uses the same codes to choose `acc0`, `acc1` or `amt_word`, using 6 bits. The amount is two's complement, from -32 to +31. A positive amount n shifts left by n, and a negative amount shifts right by its magnitude.
- R4: Mode code 0, and the spare code 3, give a logical shift. A left shift gives {guard,result} = {16'b0,op} << n. A right shift gives {result,guard} = {op,16'b0} >> n.
- R5: Mode code 1 gives an arithmetic shift. A left shift gives {guard,result} = sign-extended op << n. A right shift gives {result,guard} = {op,16'b0} shifted right arithmetically, with vacated bits taking op[15].
- R6: Carry is the last bit shifted out of the 32-bit field. For a left shift by n, this is bit 32-n of the extended source. For a right shift by m, it is bit m-1 of {op,16'b0}. An amount of zero clears carry.
- R7: In modes 0, 1 and 3, the negative flag equals result bit 15 and the zero flag is set exactly when the result is 0.
- R8: In mode code 2 (double pass), the result word is unchanged. The guard word becomes the old guard word ORed with the half that a logical shift would put in the result word. The negative and zero flags then reflect the new guard word.
- R9: The overflow flag is set only on an arithmetic left shift whose exact value op*2^n lies outside -32768..32767. It is cleared by every other operation.
- R10: While `go` is low, the result word, the guard word and the flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Perform one operation this cycle |
| mode | input | 2 | 0 logical, 1 arithmetic, 2 double pass, 3 logical |
| src_sel | input | 2 | Operand source select |
| amt_sel | input | 2 | Amount source select |
| acc0 | input | 24 | Accumulator 0 |
| acc1 | input | 24 | Accumulator 1 |
| src_word | input | 16 | Dedicated operand word |
| amt_word | input | 6 | Dedicated amount word |
| res_q | output | 16 | Result word |
| grd_q | output | 16 | Guard word |
| flag_c | output | 1 | Carry |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_vs | output | 1 | Shifter overflow |

## Verification
The double pass reads the guard word in the same cycle in which the previous operation's write to it becomes visible. The bench provokes this by issuing a standard shift and a double pass on consecutive clock edges, in both directions. It judges the combined {guard,result} pair against a 32-bit shift of the concatenated words, computed in the bench. Carry and overflow can also be set by one arithmetic left shift. Those cases are judged against arithmetic on a 64-bit integer.

// File: rtl/dsp_shift_pkg.sv
package dsp_shift_pkg;
    localparam int DW = 16;   // operand width
    localparam int AW = 6;    // amount width
    localparam int RW = 24;   // accumulator width

    typedef enum logic [1:0] {
        MD_LOGIC = 2'd0,
        MD_ARITH = 2'd1,
        MD_DOUBLE = 2'd2,
        MD_LOGIC2 = 2'd3
    } shift_mode_e;

    typedef enum logic [1:0] {
        SEL_ACC0 = 2'd0,
        SEL_ACC1 = 2'd1,
        SEL_OWN = 2'd2,
        SEL_OWN2 = 2'd3
    } src_sel_e;
endpackage

// File: rtl/dsp_shift_src_mux.sv
module dsp_shift_src_mux #(
    parameter int RW = 24,
    parameter int OW = 16
) (
    input  logic [1:0]    sel,
    input  logic [RW-1:0] acc0,
    input  logic [RW-1:0] acc1,
    input  logic [OW-1:0] own,
    output logic [OW-1:0] out
);
    always_comb begin
        unique case (sel)
            dsp_shift_pkg::SEL_ACC0: out = acc0[OW-1:0];
            dsp_shift_pkg::SEL_ACC1: out = acc1[OW-1:0];
            default:                 out = own;
        endcase
    end
endmodule

// File: rtl/dsp_shift_core.sv
module dsp_shift_core #(
    parameter int DW = 16,
    parameter int AW = 6
) (
    input  logic [DW-1:0] op,
    input  logic [AW-1:0] amt,
    input  logic [1:0]    mode,
    input  logic [DW-1:0] grd_old,
    input  logic [DW-1:0] res_old,
    output logic [DW-1:0] res_nx,
    output logic [DW-1:0] grd_nx,
    output logic          c_nx,
    output logic          v_nx
);
    localparam int FW = 2 * DW;       // full result width
    localparam int WW = 3 * DW;       // overflow probe width

    logic          go_right;
    logic          arith;
    logic [AW-1:0] mag;
    logic [FW-1:0] src_l;
    logic [FW:0]   left_x;
    logic [FW:0]   right_x;
    logic [FW-1:0] res_full;
    logic [WW-1:0] probe;
    logic [DW-1:0] half_res;
    logic [DW-1:0] half_grd;

    always_comb begin
        go_right = amt[AW-1];
        arith    = (mode == dsp_shift_pkg::MD_ARITH);
        mag      = go_right ? AW'(-amt) : amt;
        src_l    = arith ? {{DW{op[DW-1]}}, op} : {{DW{1'b0}}, op};
        left_x   = {1'b0, src_l} << mag;
        if (arith)
            right_x = $unsigned($signed({op, {DW{1'b0}}, 1'b0}) >>> mag);
        else
            right_x = {op, {DW{1'b0}}, 1'b0} >> mag;
        if (go_right) begin
            res_full = right_x[FW:1];
            c_nx     = right_x[0];
            half_res = res_full[FW-1:DW];
            half_grd = res_full[DW-1:0];
        end else begin
            res_full = left_x[FW-1:0];
            c_nx     = left_x[FW];
            half_res = res_full[DW-1:0];
            half_grd = res_full[FW-1:DW];
        end
        probe = {{(WW-DW){op[DW-1]}}, op} << mag;
        v_nx  = arith && !go_right &&
                (probe[WW-1:DW-1] != {(WW-DW+1){probe[DW-1]}});
        if (mode == dsp_shift_pkg::MD_DOUBLE) begin
            res_nx = res_old;
            grd_nx = grd_old | half_res;
        end else begin
            res_nx = half_res;
            grd_nx = half_grd;
        end
    end
endmodule

// File: rtl/dsp_shift_unit.sv
module dsp_shift_unit #(
    parameter int DW = dsp_shift_pkg::DW,
    parameter int AW = dsp_shift_pkg::AW,
    parameter int RW = dsp_shift_pkg::RW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [1:0]    mode,
    input  logic [1:0]    src_sel,
    input  logic [1:0]    amt_sel,
    input  logic [RW-1:0] acc0,
    input  logic [RW-1:0] acc1,
    input  logic [DW-1:0] src_word,
    input  logic [AW-1:0] amt_word,
    output logic [DW-1:0] res_q,
    output logic [DW-1:0] grd_q,
    output logic          flag_c,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_vs
);
    logic [DW-1:0] op;
    logic [AW-1:0] amt;
    logic [DW-1:0] res_nx;
    logic [DW-1:0] grd_nx;
    logic          c_nx;
    logic          v_nx;
    logic [DW-1:0] flag_src;
    logic          is_dbl;

    dsp_shift_src_mux #(.RW(RW), .OW(DW)) u_op_mux (
        .sel(src_sel), .acc0(acc0), .acc1(acc1), .own(src_word), .out(op)
    );

    dsp_shift_src_mux #(.RW(RW), .OW(AW)) u_amt_mux (
        .sel(amt_sel), .acc0(acc0), .acc1(acc1), .own(amt_word), .out(amt)
    );

    dsp_shift_core #(.DW(DW), .AW(AW)) u_core (
        .op(op), .amt(amt), .mode(mode), .grd_old(grd_q), .res_old(res_q),
        .res_nx(res_nx), .grd_nx(grd_nx), .c_nx(c_nx), .v_nx(v_nx)
    );

    always_comb begin
        is_dbl   = (mode == dsp_shift_pkg::MD_DOUBLE);
        flag_src = is_dbl ? grd_nx : res_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            grd_q   <= '0;
            flag_c  <= 1'b0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_vs <= 1'b0;
        end else if (go) begin
            res_q   <= res_nx;
            grd_q   <= grd_nx;
            flag_c  <= c_nx;
            flag_n  <= flag_src[DW-1];
            flag_z  <= (flag_src == '0);
            flag_vs <= v_nx;
        end
    end

    // R8: a double pass leaves the result word alone
    a_r8_dbl_keeps_res: assert property (@(posedge clk) disable iff (!rst_n)
        go && is_dbl |=> $stable(res_q));

    // R8: a double pass never clears a guard bit
    a_r8_dbl_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
        go && is_dbl |=> ((grd_q & $past(grd_q)) == $past(grd_q)));

    // R9: overflow only after an arithmetic shift
    a_r9_vs_arith_only: assert property (@(posedge clk) disable iff (!rst_n)
        go && mode != dsp_shift_pkg::MD_ARITH |=> !flag_vs);

    // R10: idle cycles hold all state
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(res_q) && $stable(grd_q) && $stable(flag_c) && $stable(flag_vs));

    // R6: zero amount clears carry
    a_r6_zero_amt_carry: assert property (@(posedge clk) disable iff (!rst_n)
        go && amt == '0 |=> !flag_c);

    // R7: zero flag follows the result word for standard shifts
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        go && !is_dbl |=> flag_z == (res_q == '0));
endmodule

// File: tb/dsp_shift_unit_tb_top.sv
module dsp_shift_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [1:0]  src_sel = 2'd2;
    logic [1:0]  amt_sel = 2'd2;
    logic [23:0] acc0 = '0;
    logic [23:0] acc1 = '0;
    logic [15:0] src_word = '0;
    logic [5:0]  amt_word = '0;
    logic [15:0] res_q, grd_q;
    logic        flag_c, flag_n, flag_z, flag_vs;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] m_res = '0;
    logic [15:0] m_grd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_shift_unit dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .src_sel(src_sel),
        .amt_sel(amt_sel), .acc0(acc0), .acc1(acc1), .src_word(src_word),
        .amt_word(amt_word), .res_q(res_q), .grd_q(grd_q), .flag_c(flag_c),
        .flag_n(flag_n), .flag_z(flag_z), .flag_vs(flag_vs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Issue one operation and compare with the bench model.
    task automatic do_op(input string tag, input logic [1:0] md, input logic [1:0] ss,
                         input logic [1:0] as, input logic [23:0] a0, input logic [23:0] a1,
                         input logic [15:0] sw, input logic [5:0] aw);
        logic [15:0] op;
        logic [5:0]  am;
        int          n;
        logic [63:0] x;
        logic [15:0] e_res, e_grd, half, fsrc;
        logic        e_c, e_v, ar;
        longint      p;
        op = (ss == 2'd0) ? a0[15:0] : (ss == 2'd1) ? a1[15:0] : sw;
        am = (as == 2'd0) ? a0[5:0] : (as == 2'd1) ? a1[5:0] : aw;
        n  = int'($signed(am));
        ar = (md == 2'd1);
        e_v = 1'b0;
        if (n >= 0) begin
            x = ar ? 64'($signed(op)) : {48'b0, op};
            x = x << n;
            e_res = x[15:0]; e_grd = x[31:16]; e_c = (n == 0) ? 1'b0 : x[32];
            half = e_res;
            p = longint'($signed(op)) * (longint'(1) << n);
            if (ar && (p > 32767 || p < -32768)) e_v = 1'b1;
        end else begin
            x = {op, 48'b0};
            x = ar ? $unsigned($signed(x) >>> (-n)) : (x >> (-n));
            e_res = x[63:48]; e_grd = x[47:32]; e_c = x[31];
            half = e_res;
        end
        if (md == 2'd2) begin
            e_grd = m_grd | half;
            e_res = m_res;
            fsrc = e_grd;
        end else begin
            fsrc = e_res;
        end
        @(negedge clk);
        mode = md; src_sel = ss; amt_sel = as; acc0 = a0; acc1 = a1;
        src_word = sw; amt_word = aw; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        m_res = e_res; m_grd = e_grd;
        chk({tag, " res"}, 32'(res_q), 32'(e_res));
        chk({tag, " grd"}, 32'(grd_q), 32'(e_grd));
        chk({tag, " C"}, 32'(flag_c), 32'(e_c));
        chk({tag, " N"}, 32'(flag_n), 32'(fsrc[15]));
        chk({tag, " Z"}, 32'(flag_z), 32'(fsrc == 16'h0));
        chk({tag, " VS"}, 32'(flag_vs), 32'(e_v));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset", {res_q, grd_q}, 32'h0);
        chk("R1 flags", {28'h0, flag_c, flag_n, flag_z, flag_vs}, 32'h0);
    endtask

    task automatic t_logical();
        do_op("R4 left 4", 2'd0, 2'd2, 2'd2, 0, 0, 16'hA5C3, 6'd4);
        do_op("R4 left 31 R6", 2'd0, 2'd2, 2'd2, 0, 0, 16'h0003, 6'd31);
        do_op("R4 right 3", 2'd0, 2'd2, 2'd2, 0, 0, 16'h8F01, 6'h3D);
        do_op("R4 right 32 R6", 2'd0, 2'd2, 2'd2, 0, 0, 16'h8001, 6'h20);
        do_op("R4 code3 right 17", 2'd3, 2'd2, 2'd2, 0, 0, 16'hF0F0, 6'h2F);
        do_op("R6 zero amt R7", 2'd0, 2'd2, 2'd2, 0, 0, 16'h8000, 6'd0);
        do_op("R7 zero result", 2'd0, 2'd2, 2'd2, 0, 0, 16'h0001, 6'h3F);
    endtask

    task automatic t_arith();
        do_op("R5 right 4 neg", 2'd1, 2'd2, 2'd2, 0, 0, 16'h9234, 6'h3C);
        do_op("R5 right 20 neg", 2'd1, 2'd2, 2'd2, 0, 0, 16'h8765, 6'h2C);
        do_op("R5 right 32 neg", 2'd1, 2'd2, 2'd2, 0, 0, 16'hC000, 6'h20);
        do_op("R5 zero amt sign", 2'd1, 2'd2, 2'd2, 0, 0, 16'hFFF0, 6'd0);
        do_op("R5 left 3 pos", 2'd1, 2'd2, 2'd2, 0, 0, 16'h0123, 6'd3);
    endtask

    task automatic t_overflow();
        do_op("R9 left ovf", 2'd1, 2'd2, 2'd2, 0, 0, 16'h4000, 6'd1);
        do_op("R9 left neg ok", 2'd1, 2'd2, 2'd2, 0, 0, 16'hC000, 6'd1);
        do_op("R9 left neg ovf", 2'd1, 2'd2, 2'd2, 0, 0, 16'hC000, 6'd2);
        do_op("R9 cleared logical", 2'd0, 2'd2, 2'd2, 0, 0, 16'h4000, 6'd1);
        do_op("R9 right no ovf", 2'd1, 2'd2, 2'd2, 0, 0, 16'h7FFF, 6'h3F);
    endtask

    task automatic t_double_left();
        logic [31:0] w;
        w = {16'h1357, 16'hF00D} << 5;
        do_op("R8 low pass", 2'd0, 2'd2, 2'd2, 0, 0, 16'hF00D, 6'd5);
        do_op("R8 high pass", 2'd2, 2'd2, 2'd2, 0, 0, 16'h1357, 6'd5);
        chk("R8 dbl left pair", {grd_q, res_q}, w);
    endtask

    task automatic t_double_right();
        logic [31:0] w;
        w = {16'h8421, 16'h7E3C} >> 7;
        do_op("R8 high pass r", 2'd0, 2'd2, 2'd2, 0, 0, 16'h8421, 6'h39);
        do_op("R8 low pass r", 2'd2, 2'd2, 2'd2, 0, 0, 16'h7E3C, 6'h39);
        chk("R8 dbl right pair", {res_q, grd_q}, w);
    endtask

    task automatic t_select();
        do_op("R2 acc0 upper ignored", 2'd0, 2'd0, 2'd2, 24'hFF1234, 24'h0, 16'h0, 6'd2);
        do_op("R2 acc1 src", 2'd0, 2'd1, 2'd2, 24'h0, 24'hAB8001, 16'h0, 6'd1);
        do_op("R3 amt acc0 low6", 2'd0, 2'd2, 2'd0, 24'hFFFFC3, 24'h0, 16'h00F0, 6'd0);
        do_op("R3 amt acc1 neg", 2'd1, 2'd2, 2'd1, 24'h0, 24'h12343E, 16'h8000, 6'd0);
        do_op("R2 code3 own", 2'd0, 2'd3, 2'd3, 24'h111111, 24'h222222, 16'h0F0F, 6'd8);
    endtask

    task automatic t_hold();
        logic [15:0] r0, g0;
        logic [3:0]  f0;
        r0 = res_q; g0 = grd_q; f0 = {flag_c, flag_n, flag_z, flag_vs};
        @(negedge clk);
        mode = 2'd1; src_sel = 2'd2; amt_sel = 2'd2; src_word = 16'h4321; amt_word = 6'd9;
        go = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 hold res", 32'(res_q), 32'(r0));
        chk("R10 hold grd", 32'(grd_q), 32'(g0));
        chk("R10 hold flags", 32'({flag_c, flag_n, flag_z, flag_vs}), 32'(f0));
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_logical();
        t_arith();
        t_overflow();
        t_double_left();
        t_double_right();
        t_select();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule